// File: doc/BRIEF.md
# Buck Regulator Mode and Fault Supervisor

This block is the digital supervisor of a synchronous step-down regulator. Every system clock it combines a set of control levels into one operating mode. The levels are:

- a supply reset and a supply-good level;
- an active-high run request;
- a three-level light-load select, given as two flags;
- an overvoltage-protection disable;
- a voltage-identification code.

From the mode it derives the commands for the low-side and high-side gate drivers, the light-load pulse-skipping enable and a power-good flag. It also keeps a sticky fault record. Overvoltage, output undervoltage and over-temperature events set that record, and it clears only on one of three specific recovery events.

Analog sensing, comparators and the modulator are outside the block. All inputs arrive as digitized, clock-synchronous flags. Nothing in this block carries a data stream, so there is no valid/ready interface. Every pin is a plain control or status level, and every output is valid in every cycle.

The fault record has two sticky bits: one for overvoltage and one for undervoltage or over-temperature. A bit can be set only while the regulator is armed, which means the supply is good, the supply reset is low, run is requested and test select is low.

Top module: `buck_mode_supervisor`

## Requirements
- R1: While `supply_rst` is high or `vcc_ok` is low, `mode_o` is 0 (lockout), `lo_gate_on` is 1, `hi_gate_off` is 1 and `out_ok` is 0. This holds whatever the state of the other inputs.
- R2: With R1 inactive and `run_req` low while `ovprot_off` is low, `mode_o` is 1 and `lo_gate_on` is 1.
- R3: With R1 inactive and `run_req` low while `ovprot_off` is high, `mode_o` is 3'd2, `lo_gate_off` is 1 and `lo_gate_on` is 0.
- R4: With run requested and `vid_code` all ones, `mode_o` is 3 and the outputs are `lo_gate_off`=1 and `hi_gate_off`=1. An undervoltage event in this mode still sets the fault record. This mode outranks the fault mode.
- R5: An armed overvoltage, undervoltage or thermal event sets the fault record at the next clock edge. After that edge, with no higher mode selected, `mode_o` is 7, `lo_gate_on` is 1 and `out_ok` is 0.
- R6: The fault record clears at the clock edge where any of these holds: `supply_rst` is high, `skipsel_neg` is high, or `run_req` is high after being low at the previous edge.
- R7: `skipsel_neg` high while running gives `mode_o`=4 (test) with `pfm_en`=1. All event inputs are ignored in this mode, and the fault record reads clear from the next edge.
- R8: While `ovprot_off` is high, overvoltage events are ignored and the overvoltage bit is cleared at each edge. Undervoltage and thermal events still set the fault record.
- R9: Out of reset with no fault, `skipsel_hi` high gives `mode_o`=6 with `pfm_en`=0 (forced PWM). Both skip flags low gives `mode_o`=5 with `pfm_en`=1.
- R10: `out_ok` is 1 exactly when `mode_o` is 4, 5 or 6 and `fb_low` is 0.
- R11: Once set, the fault record holds after all events return low, until an R6 clear occurs.
- R12: When both `skipsel_neg` and `skipsel_hi` are high, the below-ground (test) selection wins and `mode_o` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| supply_rst | input | 1 | Supply power-on reset level |
| vcc_ok | input | 1 | Supply above the lockout threshold |
| run_req | input | 1 | High requests operation; low requests shutdown |
| skipsel_neg | input | 1 | Light-load select driven below ground (test) |
| skipsel_hi | input | 1 | Light-load select high (forced PWM) |
| ovprot_off | input | 1 | Disables overvoltage protection |
| vid_code | input | VID_W | Voltage-identification code |
| ovp_evt | input | 1 | Overvoltage event |
| uvp_evt | input | 1 | Output undervoltage event |
| therm_evt | input | 1 | Over-temperature event |
| fb_low | input | 1 | Feedback more than 5% below nominal |
| mode_o | output | 3 | Operating mode code (0 to 7) |
| lo_gate_on | output | 1 | Low-side gate forced on |
| lo_gate_off | output | 1 | Low-side gate forced off |
| hi_gate_off | output | 1 | High-side gate held off (tied to switch node) |
| pfm_en | output | 1 | Automatic pulse-skipping switchover enabled |
| out_ok | output | 1 | Power-good |

## Verification
The assertions check the per-cycle rules on every cycle:
- lockout dominance;
- shutdown with protection kept;
- the clear, set and hold behaviour of each sticky bit;
- the clearing effect of test select and of protection disable;
- power-good never being high while feedback is low.

Only the bench scenarios can show the following:
- the full priority ordering across sequences;
- that a fault set under the all-ones code surfaces once the code changes;
- that the shutdown-toggle clear needs a real low-to-high transition of `run_req`;
- that undervoltage faulting survives while overvoltage protection is off.

// File: rtl/bms_pkg.sv
package bms_pkg;
  typedef enum logic [2:0] {
    M_LOCK    = 3'd0,
    M_SD_PROT = 3'd1,
    M_SD_FREE = 3'd2,
    M_SD_VID  = 3'd3,
    M_TEST    = 3'd4,
    M_AUTO    = 3'd5,
    M_PWM     = 3'd6,
    M_FAULT   = 3'd7
  } mode_e;

  localparam int unsigned NUM_FLT = 2;
  localparam int unsigned FLT_OV  = 0;
  localparam int unsigned FLT_UT  = 1;
endpackage

// File: rtl/bms_fault_latch.sv
module bms_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
  a_r5_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/bms_mode_decode.sv
module bms_mode_decode
  import bms_pkg::*;
#(
  parameter int unsigned VID_W = 5
) (
  input  logic             supply_rst,
  input  logic             vcc_ok,
  input  logic             run_req,
  input  logic             ovprot_off,
  input  logic             skipsel_neg,
  input  logic             skipsel_hi,
  input  logic [VID_W-1:0] vid_code,
  input  logic             fault_any,
  output mode_e            mode
);
  localparam logic [VID_W-1:0] VID_OFF = '1;

  always_comb begin
    if (supply_rst || !vcc_ok)  mode = M_LOCK;
    else if (!run_req)          mode = ovprot_off ? M_SD_FREE : M_SD_PROT;
    else if (vid_code == VID_OFF) mode = M_SD_VID;
    else if (fault_any)         mode = M_FAULT;
    else if (skipsel_neg)       mode = M_TEST;
    else if (skipsel_hi)        mode = M_PWM;
    else                        mode = M_AUTO;
  end
endmodule

// File: rtl/bms_gate_map.sv
module bms_gate_map
  import bms_pkg::*;
(
  input  mode_e mode,
  input  logic  fb_low,
  output logic  lo_on,
  output logic  lo_off,
  output logic  hi_off,
  output logic  pfm,
  output logic  ok
);
  logic switching;

  always_comb begin
    switching = (mode == M_TEST) || (mode == M_AUTO) || (mode == M_PWM);
    lo_on     = (mode == M_LOCK) || (mode == M_SD_PROT) || (mode == M_FAULT);
    lo_off    = (mode == M_SD_FREE) || (mode == M_SD_VID);
    hi_off    = !switching;
    pfm       = (mode == M_TEST) || (mode == M_AUTO);
    ok        = switching && !fb_low;
  end
endmodule

// File: rtl/buck_mode_supervisor.sv
module buck_mode_supervisor
  import bms_pkg::*;
#(
  parameter int unsigned VID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_rst,
  input  logic             vcc_ok,
  input  logic             run_req,
  input  logic             skipsel_neg,
  input  logic             skipsel_hi,
  input  logic             ovprot_off,
  input  logic [VID_W-1:0] vid_code,
  input  logic             ovp_evt,
  input  logic             uvp_evt,
  input  logic             therm_evt,
  input  logic             fb_low,
  output logic [2:0]       mode_o,
  output logic             lo_gate_on,
  output logic             lo_gate_off,
  output logic             hi_gate_off,
  output logic             pfm_en,
  output logic             out_ok
);
  logic               run_q;
  logic               run_rise;
  logic               armed;
  logic               common_clr;
  logic [NUM_FLT-1:0] flt_set;
  logic [NUM_FLT-1:0] flt_clr;
  logic [NUM_FLT-1:0] flt_q;
  mode_e              mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_req;
  end

  always_comb begin
    run_rise   = run_req && !run_q;
    armed      = vcc_ok && !supply_rst && run_req && !skipsel_neg;
    common_clr = supply_rst || skipsel_neg || run_rise;
    flt_set[FLT_OV] = armed && ovp_evt && !ovprot_off;
    flt_clr[FLT_OV] = common_clr || ovprot_off;
    flt_set[FLT_UT] = armed && (uvp_evt || therm_evt);
    flt_clr[FLT_UT] = common_clr;
  end

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    bms_fault_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flt_set[g]),
      .clr_i (flt_clr[g]),
      .q_o   (flt_q[g])
    );
  end

  bms_mode_decode #(.VID_W(VID_W)) u_decode (
    .supply_rst  (supply_rst),
    .vcc_ok      (vcc_ok),
    .run_req     (run_req),
    .ovprot_off  (ovprot_off),
    .skipsel_neg (skipsel_neg),
    .skipsel_hi  (skipsel_hi),
    .vid_code    (vid_code),
    .fault_any   (|flt_q),
    .mode        (mode)
  );

  bms_gate_map u_map (
    .mode   (mode),
    .fb_low (fb_low),
    .lo_on  (lo_gate_on),
    .lo_off (lo_gate_off),
    .hi_off (hi_gate_off),
    .pfm    (pfm_en),
    .ok     (out_ok)
  );

  assign mode_o = mode;

  a_r1_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_rst || !vcc_ok) |-> (mode_o == 3'd0 && lo_gate_on && hi_gate_off && !out_ok));
  a_r2_shdn_prot: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_req && !ovprot_off && vcc_ok && !supply_rst) |-> (lo_gate_on && !lo_gate_off));
  a_r7_test_clears: assert property (@(posedge clk) disable iff (!rst_n)
    skipsel_neg |=> (flt_q == '0));
  a_r8_ovp_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ovprot_off |=> !flt_q[FLT_OV]);
  a_r10_ok_fb: assert property (@(posedge clk) disable iff (!rst_n)
    out_ok |-> !fb_low);
endmodule

// File: tb/buck_mode_supervisor_tb.sv
module buck_mode_supervisor_tb;
  typedef struct {
    logic [2:0] m;
    logic       fb;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_rst = 1'b0, vcc_ok = 1'b1, run_req = 1'b1;
  logic       skipsel_neg = 1'b0, skipsel_hi = 1'b0, ovprot_off = 1'b0;
  logic [4:0] vid_code = 5'h10;
  logic       ovp_evt = 1'b0, uvp_evt = 1'b0, therm_evt = 1'b0, fb_low = 1'b0;
  logic [2:0] mode_o;
  logic       lo_gate_on, lo_gate_off, hi_gate_off, pfm_en, out_ok;

  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  buck_mode_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .supply_rst(supply_rst), .vcc_ok(vcc_ok),
    .run_req(run_req), .skipsel_neg(skipsel_neg), .skipsel_hi(skipsel_hi),
    .ovprot_off(ovprot_off), .vid_code(vid_code), .ovp_evt(ovp_evt),
    .uvp_evt(uvp_evt), .therm_evt(therm_evt), .fb_low(fb_low),
    .mode_o(mode_o), .lo_gate_on(lo_gate_on), .lo_gate_off(lo_gate_off),
    .hi_gate_off(hi_gate_off), .pfm_en(pfm_en), .out_ok(out_ok)
  );

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Push expectation for the state after the coming clock edge, then move on one cycle.
  task automatic cyc(logic [2:0] m, string tag);
    exp_t e;
    e.m = m; e.fb = fb_low; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: output levels derived per requirement from the expected mode.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        bit sw;
        e  = sb.pop_front();
        sw = (e.m == 3'd4) || (e.m == 3'd5) || (e.m == 3'd6);
        cmp(e.tag, "mode", int'(mode_o), int'(e.m));
        cmp(e.tag, "lo_on", int'(lo_gate_on), int'(e.m == 3'd0 || e.m == 3'd1 || e.m == 3'd7));
        cmp(e.tag, "lo_off", int'(lo_gate_off), int'(e.m == 3'd2 || e.m == 3'd3));
        cmp(e.tag, "hi_off", int'(hi_gate_off), int'(!sw));
        cmp(e.tag, "pfm", int'(pfm_en), int'(e.m == 3'd4 || e.m == 3'd5));
        cmp(e.tag, "ok R10", int'(out_ok), int'(sw && !e.fb));
      end
    end
  end

  initial begin
    @(negedge clk);
    cyc(3'd5, "R9 reset");
    rst_n = 1'b1;
    cyc(3'd5, "R9 auto");
    // R1 lockout
    vcc_ok = 1'b0; skipsel_hi = 1'b1; cyc(3'd0, "R1 vcc");
    vcc_ok = 1'b1; supply_rst = 1'b1; cyc(3'd0, "R1 por");
    supply_rst = 1'b0; cyc(3'd6, "R9 pwm");
    skipsel_hi = 1'b0; cyc(3'd5, "R9 auto");
    // R2 / R3 shutdown variants
    run_req = 1'b0; cyc(3'd1, "R2");
    ovprot_off = 1'b1; cyc(3'd2, "R3");
    run_req = 1'b1; ovprot_off = 1'b0; cyc(3'd5, "R9 resume");
    // R4 all-ones code, undervoltage still records a fault
    vid_code = 5'h1f; cyc(3'd3, "R4");
    uvp_evt = 1'b1; cyc(3'd3, "R4 uvp");
    uvp_evt = 1'b0; cyc(3'd3, "R4 hold");
    vid_code = 5'h10; cyc(3'd7, "R11 after R4");
    // R6 clear by test select
    skipsel_neg = 1'b1; cyc(3'd4, "R6 neg");
    skipsel_neg = 1'b0; cyc(3'd5, "R6 neg done");
    // R5 thermal, R11 hold, R6 shutdown toggle
    therm_evt = 1'b1; fb_low = 1'b1; cyc(3'd7, "R5 therm");
    therm_evt = 1'b0; fb_low = 1'b0; cyc(3'd7, "R11 hold");
    cyc(3'd7, "R11 hold2");
    run_req = 1'b0; cyc(3'd1, "R6 shdn");
    run_req = 1'b1; cyc(3'd5, "R6 toggle");
    // R5 overvoltage, R6 por clear
    ovp_evt = 1'b1; cyc(3'd7, "R5 ovp");
    ovp_evt = 1'b0; supply_rst = 1'b1; cyc(3'd0, "R6 por");
    supply_rst = 1'b0; cyc(3'd5, "R6 por done");
    // R8 protection disable
    ovprot_off = 1'b1; ovp_evt = 1'b1; cyc(3'd5, "R8 ignore");
    ovp_evt = 1'b0; ovprot_off = 1'b0; cyc(3'd5, "R8 clean");
    ovp_evt = 1'b1; cyc(3'd7, "R5 ovp2");
    ovp_evt = 1'b0; ovprot_off = 1'b1; cyc(3'd5, "R8 drop");
    uvp_evt = 1'b1; cyc(3'd7, "R8 uvp kept");
    uvp_evt = 1'b0; ovprot_off = 1'b0; skipsel_neg = 1'b1; cyc(3'd4, "R6 neg2");
    // R7 test ignores events
    ovp_evt = 1'b1; uvp_evt = 1'b1; therm_evt = 1'b1; cyc(3'd4, "R7");
    cyc(3'd4, "R7 hold");
    ovp_evt = 1'b0; uvp_evt = 1'b0; therm_evt = 1'b0; skipsel_neg = 1'b0; cyc(3'd5, "R7 exit");
    // R12 both skip flags
    skipsel_neg = 1'b1; skipsel_hi = 1'b1; cyc(3'd4, "R12");
    skipsel_neg = 1'b0; cyc(3'd6, "R9 pwm2");
    // R10 power-good
    fb_low = 1'b1; cyc(3'd6, "R10 low");
    skipsel_hi = 1'b0; cyc(3'd5, "R10 auto low");
    fb_low = 1'b0; cyc(3'd5, "R10 good");
    run_req = 1'b0; cyc(3'd1, "R10 shdn");
    run_req = 1'b1; cyc(3'd5, "R10 back");
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule